// File: doc/BRIEF.md
# Serial Audio Bit and Word Clock Generator

This block turns an oversampling master clock into the timing of a stereo serial PCM link to a DAC. A programmable prescaler divides the master clock by 2×(1+N) to make the bit clock, and the word clock marks the left and right channel slots. Each slot is either 16 or 32 bit periods long, so one word period spans 32 or 64 bit periods. In the 16-slot mode N is set to (oversampling factor / 64) − 1, and in the 32-slot mode to (oversampling factor / 128) − 1. For example, a 384× master clock with 16-bit slots needs N = 5.

During each slot the block shifts out one channel of a parallel stereo sample, MSB first. The sample precision is 16, 18, 20 or 24 bits. At the start of every frame the block pulses a request strobe and takes a fresh sample pair if the source marks it valid; otherwise it plays the previous pair again. The divider, slot mode and precision can be changed at any time, but they are applied only at the next frame boundary, so the link never sees a partial frame.

Top module: `serial_audio_clkgen`

## Requirements
- R1: After reset, and between any two frame boundaries, `bitClk` toggles exactly every 1+`divSel` master-clock cycles. The duty cycle is 50% and the period is 2×(1+`divSel`) cycles. The first toggle after reset release comes 1+`divSel` cycles after the release.
- R2: One frame contains 32 falling `bitClk` edges when `wideFrame`=0 (16 per channel) and 64 when `wideFrame`=1 (32 per channel).
- R3: `wordClk` is 0 during the left slot and 1 during the right slot. It changes only together with a falling `bitClk` edge.
- R4: `serData` changes only together with a falling `bitClk` edge and is stable while `bitClk` is high. Each slot carries its channel MSB first. Samples are MSB-aligned in the `SAMPLE_W`-bit inputs. The `precSel` codes are 0=16, 1=18, 2=20 and 3=24 bits. In the 32-slot mode, bit positions at or beyond the precision are driven as 0.
- R5: In the 16-slot mode each channel carries the 16 most significant bits of its sample, whatever the value of `precSel`.
- R6: `sampleReq` is high for exactly one master cycle, in the cycle where the left slot of a new frame begins. The `sampleLeft`/`sampleRight` values present with `sampleValid`=1 on that cycle's edge are sent in that frame. If `sampleValid` is 0 on that edge, the previously sent pair is repeated.
- R7: A synchronous `rst` drives `bitClk`, `wordClk`, `serData` and `sampleReq` low and places the block at bit 0 of a left slot. It also loads the current divider, mode and precision and clears the held sample, so the first frame after reset carries zeros.
- R8: Changes to `divSel`, `wideFrame` and `precSel` made in the middle of a frame do not alter that frame. They take effect from the frame boundary that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling master clock |
| rst | input | 1 | Synchronous reset, active high |
| divSel | input | DIV_W | Prescaler value N; bit clock = master / (2×(1+N)) |
| wideFrame | input | 1 | 0: 16 bit periods per channel, 1: 32 per channel |
| precSel | input | 2 | Sample precision code (0=16, 1=18, 2=20, 3=24 bits) |
| sampleLeft | input | SAMPLE_W | Left sample, MSB-aligned |
| sampleRight | input | SAMPLE_W | Right sample, MSB-aligned |
| sampleValid | input | 1 | A new sample pair is offered |
| bitClk | output | 1 | Serial bit clock |
| wordClk | output | 1 | Left/right word clock (0 = left) |
| serData | output | 1 | Serial sample data, MSB first |
| sampleReq | output | 1 | One-cycle strobe at the start of each frame |

## Verification
The bench builds the block with its defaults: an 8-bit divider field and 24-bit sample inputs. The divider is driven between 0 and 5, which covers the one-cycle half period and the 384× ratio. With these values, both slot modes, all four precision codes and the truncation in the 16-slot mode are all reachable within a few thousand cycles. Random sample pairs and random `sampleValid` values exercise the repeat path. A mid-frame change of divider, mode and precision checks that every setting is held until the next frame boundary.

// File: rtl/sacg_pkg.sv
package sacg_pkg;

  localparam int POS_W = 5;
  localparam int WID_W = 5;

  typedef struct packed {
    logic              shift;
    logic              frameStart;
    logic              right;
    logic [POS_W-1:0]  pos;
    logic [WID_W-1:0]  width;
  } dpStrobeT;

  function automatic logic [WID_W-1:0] precBits(input logic [1:0] code);
    case (code)
      2'd0:    precBits = WID_W'(16);
      2'd1:    precBits = WID_W'(18);
      2'd2:    precBits = WID_W'(20);
      default: precBits = WID_W'(24);
    endcase
  endfunction

endpackage

// File: rtl/sacg_ctrl.sv
module sacg_ctrl
  import sacg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divSel,
  input  logic             wideFrame,
  input  logic [1:0]       precSel,
  output logic             bitClk,
  output logic             wordClk,
  output logic             sampleReq,
  output dpStrobeT         strobe
);

  localparam int IDX_W = 6;
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(31);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(63);
  localparam logic [IDX_W-1:0] SLOT_NARROW = IDX_W'(16);
  localparam logic [IDX_W-1:0] SLOT_WIDE   = IDX_W'(32);

  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] activeDiv;
  logic             activeWide;
  logic [1:0]       activePrec;
  logic [IDX_W-1:0] bitIdx;

  logic             tick;
  logic             fall;
  logic             wrap;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] slotLen;
  logic [IDX_W-1:0] posFull;
  logic             newWide;
  logic [1:0]       newPrec;
  logic             nextRight;

  always_comb begin
    tick      = (preCnt == activeDiv);
    fall      = tick && bitClk;
    lastIdx   = activeWide ? LAST_WIDE : LAST_NARROW;
    wrap      = fall && (bitIdx == lastIdx);
    nextIdx   = wrap ? '0 : bitIdx + IDX_W'(1);
    newWide   = wrap ? wideFrame : activeWide;
    newPrec   = wrap ? precSel : activePrec;
    slotLen   = newWide ? SLOT_WIDE : SLOT_NARROW;
    nextRight = (nextIdx >= slotLen);
    posFull   = nextRight ? (nextIdx - slotLen) : nextIdx;

    strobe.shift      = fall;
    strobe.frameStart = wrap;
    strobe.right      = nextRight;
    strobe.pos        = posFull[POS_W-1:0];
    strobe.width      = newWide ? precBits(newPrec) : WID_W'(16);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt     <= '0;
      bitClk     <= 1'b0;
      wordClk    <= 1'b0;
      bitIdx     <= '0;
      sampleReq  <= 1'b0;
      activeDiv  <= divSel;
      activeWide <= wideFrame;
      activePrec <= precSel;
    end else begin
      preCnt    <= tick ? '0 : preCnt + DIV_W'(1);
      sampleReq <= wrap;
      if (tick) begin
        bitClk <= ~bitClk;
      end
      if (fall) begin
        bitIdx  <= nextIdx;
        wordClk <= nextRight;
      end
      if (wrap) begin
        activeDiv  <= divSel;
        activeWide <= wideFrame;
        activePrec <= precSel;
      end
    end
  end

endmodule

// File: rtl/sacg_datapath.sv
module sacg_datapath
  import sacg_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  dpStrobeT            strobe,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                sampleValid,
  output logic                serData
);

  logic [SAMPLE_W-1:0] holdLeft;
  logic [SAMPLE_W-1:0] holdRight;
  logic [SAMPLE_W-1:0] curLeft;
  logic [SAMPLE_W-1:0] curRight;
  logic [SAMPLE_W-1:0] chosen;
  logic [SAMPLE_W-1:0] shifted;
  logic                takeNew;
  logic                bitOut;

  always_comb begin
    takeNew  = strobe.frameStart && sampleValid;
    curLeft  = takeNew ? sampleLeft  : holdLeft;
    curRight = takeNew ? sampleRight : holdRight;
    chosen   = strobe.right ? curRight : curLeft;
    shifted  = chosen << strobe.pos;
    bitOut   = (strobe.pos < strobe.width) ? shifted[SAMPLE_W-1] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdLeft  <= '0;
      holdRight <= '0;
      serData   <= 1'b0;
    end else begin
      if (takeNew) begin
        holdLeft  <= sampleLeft;
        holdRight <= sampleRight;
      end
      if (strobe.shift) begin
        serData <= bitOut;
      end
    end
  end

endmodule

// File: rtl/serial_audio_clkgen.sv
module serial_audio_clkgen
  import sacg_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    divSel,
  input  logic                wideFrame,
  input  logic [1:0]          precSel,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                sampleValid,
  output logic                bitClk,
  output logic                wordClk,
  output logic                serData,
  output logic                sampleReq
);

  dpStrobeT strobe;

  sacg_ctrl #(.DIV_W(DIV_W)) ctrl (
    .clk       (clk),
    .rst       (rst),
    .divSel    (divSel),
    .wideFrame (wideFrame),
    .precSel   (precSel),
    .bitClk    (bitClk),
    .wordClk   (wordClk),
    .sampleReq (sampleReq),
    .strobe    (strobe)
  );

  sacg_datapath #(.SAMPLE_W(SAMPLE_W)) dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .sampleLeft  (sampleLeft),
    .sampleRight (sampleRight),
    .sampleValid (sampleValid),
    .serData     (serData)
  );

endmodule

// File: rtl/serial_audio_clkgen_chk.sv
module serial_audio_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic bitClk,
  input logic wordClk,
  input logic serData,
  input logic sampleReq
);

  // R3: the word clock moves only with a falling bit clock
  a_r3_word_on_fall: assert property (@(posedge clk) disable iff (rst)
    (wordClk != $past(wordClk)) |-> ($past(bitClk) && !bitClk));

  // R4: serial data moves only with a falling bit clock
  a_r4_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    (serData != $past(serData)) |-> ($past(bitClk) && !bitClk));

  // R6: request strobe lasts one master cycle
  a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
    sampleReq |=> !sampleReq);

  // R6: request strobe marks a falling edge into a left slot
  a_r6_req_left: assert property (@(posedge clk) disable iff (rst)
    sampleReq |-> (!wordClk && $past(bitClk) && !bitClk));

  // R7: outputs idle right after a reset cycle
  a_r7_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!bitClk && !wordClk && !serData && !sampleReq));

endmodule

bind serial_audio_clkgen serial_audio_clkgen_chk chk (
  .clk       (clk),
  .rst       (rst),
  .bitClk    (bitClk),
  .wordClk   (wordClk),
  .serData   (serData),
  .sampleReq (sampleReq)
);

// File: tb/serial_audio_clkgen_test.sv
`timescale 1ns/1ps
module serial_audio_clkgen_test;

  localparam int DIV_W    = 8;
  localparam int SAMPLE_W = 24;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [DIV_W-1:0]    divSel = '0;
  logic                wideFrame = 1'b0;
  logic [1:0]          precSel = '0;
  logic [SAMPLE_W-1:0] sampleLeft = '0;
  logic [SAMPLE_W-1:0] sampleRight = '0;
  logic                sampleValid = 1'b0;
  logic                bitClk, wordClk, serData, sampleReq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  serial_audio_clkgen #(.DIV_W(DIV_W), .SAMPLE_W(SAMPLE_W)) uut (
    .clk(clk), .rst(rst), .divSel(divSel), .wideFrame(wideFrame),
    .precSel(precSel), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .sampleValid(sampleValid), .bitClk(bitClk), .wordClk(wordClk),
    .serData(serData), .sampleReq(sampleReq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int precWidth(input logic [1:0] code);
    case (code)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [63:0] expFrame(input logic [23:0] l, input logic [23:0] r,
                                           input logic wide, input logic [1:0] prec);
    logic [63:0] v = '0;
    int slot = wide ? 32 : 16;
    int w = wide ? precWidth(prec) : 16;
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < slot; p++) begin
        logic b;
        b = (p < w) ? (ch == 1 ? r[23-p] : l[23-p]) : 1'b0;
        v = {v[62:0], b};
      end
    end
    return v;
  endfunction

  // monitor state
  logic        prevBit;
  int          halfCnt;
  int          expDiv;
  logic        expWide;
  logic [1:0]  expPrec;
  logic [23:0] expL, expR;
  logic [63:0] cap;
  int          rises, falls;
  bit          lastRepeat;

  always @(negedge clk) begin
    if (rst) begin
      prevBit    = 1'b0;
      halfCnt    = 0;
      expDiv     = int'(divSel);
      expWide    = wideFrame;
      expPrec    = precSel;
      expL       = '0;
      expR       = '0;
      cap        = '0;
      rises      = 0;
      falls      = 0;
      lastRepeat = 1'b0;
    end else begin
      halfCnt++;
      if (bitClk != prevBit) begin
        chk(halfCnt == expDiv + 1, "R1 half period", halfCnt, expDiv + 1);
        halfCnt = 0;
        if (bitClk) begin
          chk(wordClk == (rises >= (expWide ? 32 : 16)), "R3 word clock", wordClk,
              (rises >= (expWide ? 32 : 16)));
          cap = {cap[62:0], serData};
          rises++;
        end else begin
          falls++;
        end
      end
      prevBit = bitClk;
      if (sampleReq) begin
        chk(falls == (expWide ? 64 : 32), "R2 frame length", falls, expWide ? 64 : 32);
        if (lastRepeat)
          chk(cap == expFrame(expL, expR, expWide, expPrec), "R6 repeated frame", cap,
              expFrame(expL, expR, expWide, expPrec));
        else if (expWide)
          chk(cap == expFrame(expL, expR, expWide, expPrec), "R4 wide frame data", cap,
              expFrame(expL, expR, expWide, expPrec));
        else
          chk(cap == expFrame(expL, expR, expWide, expPrec), "R5 narrow frame data", cap,
              expFrame(expL, expR, expWide, expPrec));
        expDiv  = int'(divSel);
        expWide = wideFrame;
        expPrec = precSel;
        lastRepeat = !sampleValid;
        if (sampleValid) begin
          expL = sampleLeft;
          expR = sampleRight;
        end
        cap   = '0;
        rises = 0;
        falls = 0;
      end
    end
  end

  task automatic newSample(input int validPct);
    sampleLeft  = SAMPLE_W'($urandom);
    sampleRight = SAMPLE_W'($urandom);
    sampleValid = ($urandom % 100) < validPct;
  endtask

  task automatic waitReq();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sampleReq && n < 20000);
    if (!sampleReq) chk(1'b0, "WDOG request", n, 0);
    #1;
  endtask

  task automatic runFrames(input int n, input int validPct);
    for (int i = 0; i < n; i++) begin
      waitReq();
      newSample(validPct);
    end
  endtask

  task automatic doReset(input int dv, input logic wd, input logic [1:0] pr);
    @(negedge clk); #1;
    rst = 1'b1;
    divSel = DIV_W'(dv);
    wideFrame = wd;
    precSel = pr;
    newSample(100);
    repeat (3) @(negedge clk);
    // R7: reset state
    chk({bitClk, wordClk, serData, sampleReq} == 4'b0, "R7 reset outputs",
        {bitClk, wordClk, serData, sampleReq}, 0);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    // directed: 384x, narrow slots, 24-bit precision truncated
    doReset(5, 1'b0, 2'd3);
    runFrames(4, 100);
    // directed: fastest divider, wide slots, 16-bit precision
    doReset(0, 1'b1, 2'd0);
    runFrames(4, 100);
    // directed: wide slots, 18-bit precision, no new samples
    doReset(1, 1'b1, 2'd1);
    runFrames(2, 100);
    runFrames(3, 0);
    // random configurations
    for (int k = 0; k < 8; k++) begin
      doReset(int'($urandom % 6), 1'(($urandom)), 2'($urandom));
      runFrames(3, 70);
    end
    // R8: mid-frame reconfiguration without reset
    doReset(2, 1'b0, 2'd2);
    runFrames(2, 100);
    repeat (20 + int'($urandom % 40)) @(negedge clk);
    #1;
    divSel = DIV_W'(4);
    wideFrame = 1'b1;
    precSel = 2'd2;
    runFrames(2, 100);
    repeat (30 + int'($urandom % 100)) @(negedge clk);
    #1;
    divSel = DIV_W'(0);
    wideFrame = 1'b0;
    precSel = 2'd3;
    runFrames(3, 80);
    chk(1'b1, "R8 reconfiguration run", 0, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk(1'b0, "WDOG global", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule